// File: doc/BRIEF.md
# Digital Closed-Loop Trim Controller

This block keeps up to six power-supply outputs on target by stepping each channel's 8-bit trim DAC code according to ADC measurements. A free-running interval timer starts a correction pass at one of four selectable rates. During a pass the block asks for one measurement at a time, for each selected channel in ascending index order. It compares each returned sample against that channel's setpoint and moves the code one LSB toward the setpoint. The direction of the step depends on a per-channel polarity bit.

Four setpoint profiles are supplied, and a 2-bit select picks one profile for all channels at once. Correction runs only while the active-low enable is low. While the enable is high the codes hold their values. A per-channel lock bit and a combined lock output show when the selected channels have settled. The ADC and DACs are external: the block issues a request with a channel number and accepts a tagged sample back.

Top module: `loop_trim_ctrl`

## Requirements
- R1: After reset every channel code is 0x80, every lock bit is 0, the combined lock is 0 and no measurement request is issued.
- R2: While `trim_en_n` is high, no request is issued and no code changes. With `trim_en_n` low from reset, the first request follows within 2^BASE_LOG + 6 cycles.
- R3: While enabled, successive passes start exactly 2^(BASE_LOG + 2*rate_sel) cycles apart (BASE_LOG defaults to 10).
- R4: The setpoint for channel c is read from `sp_table[(p*NCH + c)*ADC_W +: ADC_W]`, where p is `prof_sel`.
- R5: Each accepted sample moves that channel's code by at most one. If the sample is more than one LSB below the setpoint, the code rises when polarity is 1 and falls when polarity is 0. If the sample is more than one LSB above the setpoint, the step is reversed. The code saturates at 0x00 and 0xFF.
- R6: Only channels whose `ch_sel` bit is 1 are requested or updated. With no channel selected, no request is issued.
- R7: A channel's lock bit becomes 1 when an accepted sample is within one LSB of the setpoint, and returns to 0 on a sample outside that window. A deselected channel's lock bit is 0.
- R8: `all_lock` is 1 only when at least one channel is selected and every selected channel's lock bit is 1.
- R9: A sample whose tag differs from the channel being awaited is ignored. The block keeps waiting for the correct tag.
- R10: Requests are single-cycle pulses with one outstanding at a time, issued in ascending channel order within a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trim_en_n | input | 1 | Active-low enable for closed-loop correction |
| prof_sel | input | 2 | Setpoint profile select, shared by all channels |
| sp_table | input | NPROF*NCH*ADC_W | Setpoints for all profiles and channels |
| rate_sel | input | 2 | Pass interval select |
| ch_sel | input | NCH | Channels taking part in closed-loop trim |
| ch_pol | input | NCH | Per-channel step polarity |
| adc_req | output | 1 | Measurement request pulse |
| adc_ch | output | CH_W | Channel to measure |
| adc_valid | input | 1 | Sample valid |
| adc_tag | input | CH_W | Channel the sample belongs to |
| adc_data | input | ADC_W | Sample value |
| dac_codes | output | NCH*CODE_W | Trim codes, channel c at bits [c*CODE_W +: CODE_W] |
| ch_lock | output | NCH | Per-channel lock |
| all_lock | output | 1 | All selected channels locked |

## Verification
The hardest states to reach are the code rails. A trimmed channel normally settles near mid-scale, so 0x00 and 0xFF are seen only when a setpoint lies beyond what the modelled supply can produce. The bench selects a profile whose setpoints are out of reach in both directions and for both polarities. It then runs more than a hundred passes at a shortened base interval. A stray sample tag is also injected while a channel is being awaited, and the bench confirms that nothing moves until the correct tag arrives.

// File: rtl/loop_trim_pkg.sv
`timescale 1ns/1ps
package loop_trim_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_REQ,
        SEQ_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_RAISE,
        ACT_LOWER
    } meas_act_e;

    // Decide which way the measurement must move; a 1-LSB band around the setpoint holds.
    function automatic meas_act_e judge(input logic [15:0] meas, input logic [15:0] sp);
        logic [16:0] m;
        logic [16:0] s;
        m = {1'b0, meas};
        s = {1'b0, sp};
        if (m + 17'd1 < s) return ACT_RAISE;
        if (m > s + 17'd1) return ACT_LOWER;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/trim_rate_timer.sv
`timescale 1ns/1ps
module trim_rate_timer
    import loop_trim_pkg::*;
#(
    parameter int BASE_LOG = 10,
    parameter int STEP_LOG = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int CNT_W = BASE_LOG + 3 * STEP_LOG;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   limit;

    always_comb begin
        limit = (CNT_W + 1)'(1) << (BASE_LOG + STEP_LOG * int'(rate_sel));
        tick  = en && ({1'b0, cnt} >= limit - (CNT_W + 1)'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        (en && $stable(rate_sel)) |-> ({1'b0, cnt} < limit));

    a_r2_timer_clear: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

endmodule

// File: rtl/trim_seq.sv
`timescale 1ns/1ps
module trim_seq
    import loop_trim_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic [NCH-1:0]  ch_sel,
    input  logic            adc_valid,
    input  logic [CH_W-1:0] adc_tag,
    output logic            adc_req,
    output logic [CH_W-1:0] adc_ch,
    output logic [NCH-1:0]  upd_vec
);
    seq_state_e      state;
    logic [CH_W-1:0] cur;
    logic [CH_W:0]   first_pick;
    logic [CH_W:0]   next_pick;
    logic            accept;

    // Lowest selected channel with index at or above 'from'; MSB flags a hit.
    function automatic logic [CH_W:0] seek(input logic [NCH-1:0] sel, input int from);
        logic [CH_W:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (i >= from && sel[i]) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    always_comb begin
        first_pick = seek(ch_sel, 0);
        next_pick  = seek(ch_sel, int'(cur) + 1);
        accept     = en && (state == SEQ_WAIT) && adc_valid && (adc_tag == cur);
        adc_req    = (state == SEQ_REQ);
        adc_ch     = cur;
        upd_vec    = '0;
        if (accept) upd_vec[cur] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cur   <= '0;
        end else if (!en) begin
            state <= SEQ_IDLE;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (tick && first_pick[CH_W]) begin
                        cur   <= first_pick[CH_W-1:0];
                        state <= SEQ_REQ;
                    end
                end
                SEQ_REQ: state <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (accept) begin
                        if (next_pick[CH_W]) begin
                            cur   <= next_pick[CH_W-1:0];
                            state <= SEQ_REQ;
                        end else begin
                            state <= SEQ_IDLE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        adc_req |=> !adc_req);

    a_r6_req_selected: assert property (@(posedge clk) disable iff (rst)
        adc_req |-> ch_sel[adc_ch]);

    a_r2_no_req_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !adc_req);

    a_r9_one_update: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_vec));

endmodule

// File: rtl/trim_chan.sv
`timescale 1ns/1ps
module trim_chan
    import loop_trim_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int ADC_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              active,
    input  logic              pol,
    input  logic [ADC_W-1:0]  meas,
    input  logic [ADC_W-1:0]  sp,
    output logic [CODE_W-1:0] code,
    output logic              lock
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    meas_act_e act;
    logic      go_up;

    always_comb begin
        act   = judge(16'(meas), 16'(sp));
        go_up = ((act == ACT_RAISE) == pol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= MID_CODE;
            lock <= 1'b0;
        end else if (!active) begin
            lock <= 1'b0;
        end else if (upd) begin
            lock <= (act == ACT_HOLD);
            if (act != ACT_HOLD) begin
                if (go_up && code != '1) code <= code + 1'b1;
                else if (!go_up && code != '0) code <= code - 1'b1;
            end
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code == MID_CODE && !lock));

    a_r5_one_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(code) |-> ($past(upd) &&
            ((CODE_W'(code - $past(code)) == CODE_W'(1)) ||
             (CODE_W'($past(code) - code) == CODE_W'(1)))));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(code));

    a_r7_lock_cleared: assert property (@(posedge clk) disable iff (rst)
        !active |=> !lock);

endmodule

// File: rtl/loop_trim_ctrl.sv
`timescale 1ns/1ps
module loop_trim_ctrl
    import loop_trim_pkg::*;
#(
    parameter int NCH      = 6,
    parameter int CODE_W   = 8,
    parameter int ADC_W    = 10,
    parameter int NPROF    = 4,
    parameter int BASE_LOG = 10,
    parameter int STEP_LOG = 2,
    parameter int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         trim_en_n,
    input  logic [1:0]                   prof_sel,
    input  logic [NPROF*NCH*ADC_W-1:0]   sp_table,
    input  logic [1:0]                   rate_sel,
    input  logic [NCH-1:0]               ch_sel,
    input  logic [NCH-1:0]               ch_pol,
    output logic                         adc_req,
    output logic [CH_W-1:0]              adc_ch,
    input  logic                         adc_valid,
    input  logic [CH_W-1:0]              adc_tag,
    input  logic [ADC_W-1:0]             adc_data,
    output logic [NCH*CODE_W-1:0]        dac_codes,
    output logic [NCH-1:0]               ch_lock,
    output logic                         all_lock
);
    logic           en;
    logic           tick;
    logic [NCH-1:0] upd_vec;

    assign en = !trim_en_n;

    trim_rate_timer #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG)) u_timer (
        .clk(clk), .rst(rst), .en(en), .rate_sel(rate_sel), .tick(tick)
    );

    trim_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .ch_sel(ch_sel),
        .adc_valid(adc_valid), .adc_tag(adc_tag),
        .adc_req(adc_req), .adc_ch(adc_ch), .upd_vec(upd_vec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [ADC_W-1:0] sp_c;
        assign sp_c = sp_table[(int'(prof_sel) * NCH + c) * ADC_W +: ADC_W];

        trim_chan #(.CODE_W(CODE_W), .ADC_W(ADC_W)) u_chan (
            .clk(clk), .rst(rst), .upd(upd_vec[c]), .active(ch_sel[c]),
            .pol(ch_pol[c]), .meas(adc_data), .sp(sp_c),
            .code(dac_codes[c*CODE_W +: CODE_W]), .lock(ch_lock[c])
        );
    end

    assign all_lock = (|ch_sel) && ((ch_lock & ch_sel) == ch_sel);

    a_r8_needs_selection: assert property (@(posedge clk) disable iff (rst)
        all_lock |-> (|ch_sel));

    a_r6_no_update_unselected: assert property (@(posedge clk) disable iff (rst)
        (upd_vec & ~ch_sel) == '0);

endmodule

// File: tb/loop_trim_ctrl_tb.sv
`timescale 1ns/1ps
module loop_trim_ctrl_tb;
    localparam int NCH = 6, CODE_W = 8, ADC_W = 10, NPROF = 4;
    localparam int BASE = 6, STEP = 2, CH_W = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                       rst, trim_en_n, adc_valid, adc_req, all_lock;
    logic [1:0]                 prof_sel, rate_sel;
    logic [NPROF*NCH*ADC_W-1:0] sp_table;
    logic [NCH-1:0]             ch_sel, ch_pol, ch_lock;
    logic [CH_W-1:0]            adc_ch, adc_tag;
    logic [ADC_W-1:0]           adc_data;
    logic [NCH*CODE_W-1:0]      dac_codes;

    loop_trim_ctrl #(.NCH(NCH), .CODE_W(CODE_W), .ADC_W(ADC_W), .NPROF(NPROF),
                     .BASE_LOG(BASE), .STEP_LOG(STEP)) u_dut (
        .clk(clk), .rst(rst), .trim_en_n(trim_en_n), .prof_sel(prof_sel),
        .sp_table(sp_table), .rate_sel(rate_sel), .ch_sel(ch_sel), .ch_pol(ch_pol),
        .adc_req(adc_req), .adc_ch(adc_ch), .adc_valid(adc_valid), .adc_tag(adc_tag),
        .adc_data(adc_data), .dac_codes(dac_codes), .ch_lock(ch_lock), .all_lock(all_lock)
    );

    typedef struct {int ch; int code; bit lock; bit all;} item_t;
    item_t q[$];

    int errors = 0, checks = 0, cyc = 0;
    int starts = 0, t_prev = 0, t_last = 0, req_cnt = 0, last_ch = -1;
    bit bad_tag = 0;
    int exp_code[NCH];
    bit exp_lock[NCH];
    int offs[NCH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int code_of(input int ch);
        return int'(dac_codes[ch*CODE_W +: CODE_W]);
    endfunction

    function automatic int plant(input int ch, input int code);
        int m;
        m = ch_pol[ch] ? (offs[ch] + 2 * code) : (offs[ch] - 2 * code);
        if (m < 0) m = 0;
        if (m > 1023) m = 1023;
        return m;
    endfunction

    function automatic int sp_of(input int p, input int ch);
        return int'(sp_table[(p * NCH + ch) * ADC_W +: ADC_W]);
    endfunction

    function automatic bit exp_all();
        bit any = 0, all = 1;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) begin
                any = 1;
                if (!exp_lock[i]) all = 0;
            end
        end
        return any && all;
    endfunction

    function automatic int lowest_sel();
        for (int i = 0; i < NCH; i++) if (ch_sel[i]) return i;
        return -1;
    endfunction

    task automatic set_sp(input int p, input int ch, input int v);
        sp_table[(p * NCH + ch) * ADC_W +: ADC_W] = ADC_W'(v);
    endtask

    // Responder: models the ADC and pushes expected results into the scoreboard.
    initial begin
        adc_valid = 0; adc_tag = '0; adc_data = '0;
        forever begin
            @(negedge clk);
            while (adc_req === 1'b1) begin
                int ch, m, s, nc;
                item_t it;
                ch = int'(adc_ch);
                req_cnt++;
                chk(ch_sel[ch], "R6 request for selected channel", ch, lowest_sel());
                if (ch == lowest_sel()) begin
                    starts++; t_prev = t_last; t_last = cyc;
                end else begin
                    chk(ch > last_ch, "R10 ascending request order", ch, last_ch + 1);
                end
                last_ch = ch;
                @(negedge clk);
                chk(!adc_req, "R10 single-cycle request", int'(adc_req), 0);
                if (bad_tag) begin
                    adc_valid = 1; adc_tag = CH_W'((ch + 1) % NCH); adc_data = '0;
                    @(negedge clk);
                    adc_valid = 0;
                    chk(code_of(ch) == exp_code[ch], "R9 stray tag ignored (awaited)", code_of(ch), exp_code[ch]);
                    chk(code_of((ch + 1) % NCH) == exp_code[(ch + 1) % NCH], "R9 stray tag ignored (tagged)",
                        code_of((ch + 1) % NCH), exp_code[(ch + 1) % NCH]);
                    chk(!adc_req, "R9 still waiting after stray tag", int'(adc_req), 0);
                    bad_tag = 0;
                end
                m = plant(ch, exp_code[ch]);
                s = sp_of(int'(prof_sel), ch);
                nc = exp_code[ch];
                if (m + 1 >= s && m <= s + 1) begin
                    exp_lock[ch] = 1;
                end else begin
                    bit up;
                    up = (m < s) ? ch_pol[ch] : !ch_pol[ch];
                    exp_lock[ch] = 0;
                    if (up && nc < 255) nc++;
                    else if (!up && nc > 0) nc--;
                end
                exp_code[ch] = nc;
                it.ch = ch; it.code = nc; it.lock = exp_lock[ch]; it.all = exp_all();
                q.push_back(it);
                adc_valid = 1; adc_tag = CH_W'(ch); adc_data = ADC_W'(m);
                @(negedge clk);
                adc_valid = 0;
            end
        end
    end

    // Monitor: pops expected results after the update edge and compares.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(code_of(it.ch) == it.code, "R4,R5 code after sample", code_of(it.ch), it.code);
                chk(ch_lock[it.ch] == it.lock, "R7 lock after sample", int'(ch_lock[it.ch]), int'(it.lock));
                chk(all_lock == it.all, "R8 combined lock", int'(all_lock), int'(it.all));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    task automatic wait_starts(input int n);
        int tgt;
        tgt = starts + n;
        wait (starts >= tgt);
        repeat (40) @(negedge clk);
    endtask

    task automatic measure(input int r);
        int p;
        rate_sel = 2'(r);
        wait_starts(2);
        wait_starts(1);
        p = 1 << (BASE + 2 * r);
        chk(t_last - t_prev == p, "R3 pass interval", t_last - t_prev, p);
    endtask

    initial begin
        int c0, rq0;
        rst = 1; trim_en_n = 1; prof_sel = 0; rate_sel = 0;
        ch_sel = 6'b101111; ch_pol = 6'b101101; sp_table = '0;
        for (int i = 0; i < NCH; i++) begin
            exp_code[i] = 128; exp_lock[i] = 0;
            offs[i] = ch_pol[i] ? 100 : 900;
        end
        set_sp(0,0,370); set_sp(0,1,630); set_sp(0,2,340); set_sp(0,3,357); set_sp(0,4,600); set_sp(0,5,400);
        set_sp(1,0,350); set_sp(1,1,660); set_sp(1,2,380); set_sp(1,3,300); set_sp(1,4,600); set_sp(1,5,356);
        set_sp(2,0,1023); set_sp(2,1,1023); set_sp(2,2,0); set_sp(2,3,357); set_sp(2,4,600); set_sp(2,5,356);
        set_sp(3,0,356); set_sp(3,1,644); set_sp(3,2,356); set_sp(3,3,356); set_sp(3,4,644); set_sp(3,5,356);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int i = 0; i < NCH; i++)
            chk(code_of(i) == 128, "R1 reset code", code_of(i), 128);
        chk(ch_lock == '0, "R1 reset lock", int'(ch_lock), 0);
        chk(!all_lock && !adc_req, "R1 reset outputs", int'({all_lock, adc_req}), 0);

        repeat (300) @(negedge clk);
        chk(req_cnt == 0, "R2 no requests while disabled", req_cnt, 0);
        chk(code_of(0) == 128, "R2 code held while disabled", code_of(0), 128);

        c0 = cyc;
        trim_en_n = 0;
        wait (starts > 0);
        chk(t_last - c0 <= (1 << BASE) + 6, "R2 start after enable", t_last - c0, (1 << BASE) + 6);
        wait_starts(30);
        chk(all_lock, "R8 all selected locked", int'(all_lock), 1);
        chk(code_of(4) == 128, "R6 unselected code untouched", code_of(4), 128);

        measure(0);
        measure(1);
        measure(2);
        rate_sel = 0;
        wait_starts(1);

        prof_sel = 1;
        wait_starts(35);
        chk(all_lock, "R4 relock on new profile", int'(all_lock), 1);
        begin
            int m0;
            m0 = plant(0, code_of(0));
            chk(m0 >= 349 && m0 <= 351, "R4 profile 1 setpoint reached", m0, 350);
        end

        trim_en_n = 1;
        ch_sel = 6'b111111;
        @(negedge clk);
        chk(!all_lock, "R8 newly selected unlocked channel", int'(all_lock), 0);
        rq0 = req_cnt;
        repeat (2000) @(negedge clk);
        chk(req_cnt == rq0, "R2 no requests after disable", req_cnt, rq0);
        for (int i = 0; i < NCH; i++)
            chk(code_of(i) == exp_code[i], "R2 codes held after disable", code_of(i), exp_code[i]);

        bad_tag = 1;
        trim_en_n = 0;
        wait_starts(30);
        chk(all_lock, "R8 six channels locked", int'(all_lock), 1);

        prof_sel = 2;
        wait_starts(140);
        chk(code_of(0) == 255, "R5 saturate at 0xFF", code_of(0), 255);
        chk(code_of(1) == 0, "R5 saturate at 0x00 (polarity 0)", code_of(1), 0);
        chk(code_of(2) == 0, "R5 saturate at 0x00 (polarity 1)", code_of(2), 0);
        chk(!ch_lock[0] && !all_lock, "R7 no lock outside window", int'({ch_lock[0], all_lock}), 0);

        trim_en_n = 1;
        ch_sel = '0;
        for (int i = 0; i < NCH; i++) exp_lock[i] = 0;
        repeat (2) @(negedge clk);
        chk(ch_lock == '0, "R7 deselected locks cleared", int'(ch_lock), 0);
        chk(!all_lock, "R8 no selection gives no lock", int'(all_lock), 0);
        rq0 = req_cnt;
        trim_en_n = 0;
        repeat (400) @(negedge clk);
        chk(req_cnt == rq0, "R6 no requests with empty selection", req_cnt, rq0);

        finish_up();
    end

endmodule